// File: doc/BRIEF.md
# Display Output Resource Allocator

This block arbitrates the shared resources needed to light up a display head. A request names the kind of output wanted (DisplayPort, a single-link digital output such as DVI, HDMI or LVDS, a dual-link DVI output, or an analog output). The allocator grants a timing controller plus the clock, encoder, transmitter link and DAC that the output kind needs, or it rejects the request with a reason code. The pool holds six timing controllers, two programmable PLLs, two DACs and three transmitters. Each transmitter has two links, A and B, and each link has its own digital encoder.

Requests are handled one at a time. A request is accepted while `busy` is low. The block then spends one cycle checking the pool and one cycle committing the result, and then emits a one-cycle response. A separate release port returns everything that a given head was granted. The block keeps track of ownership only. It carries no pixel data and makes no clocks.

Top module: `display_alloc`

Kind codes on `req_kind`: 0 = DisplayPort, 1 = single-link digital, 2 = dual-link DVI, 3 = analog. Reason codes on `rsp_reason`: 0 = granted, 1 = no timing controller, 2 = no PLL, 3 = no DAC, 4 = no suitable link. Link masks on `rsp_links`: bit 0 = link A, bit 1 = link B.

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is then high for exactly two cycles. In the cycle after that, `rsp_valid` is high for one cycle and `busy` is low.
- R2: Every grant takes the lowest-numbered free timing controller, reported on `rsp_head`. When all six are taken, the request is rejected with reason 1.
- R3: A DisplayPort grant uses no PLL (`rsp_pll_used`=0). It takes the lowest-numbered free link, where link n is transmitter n/2 and side A when n is even, B when n is odd. The encoder index equals n, `rsp_xmit` equals n/2, and `rsp_links` is 01 for side A or 10 for side B.
- R4: A single-link digital grant takes a link and an encoder exactly as in R3, and in addition takes the lowest-numbered free PLL.
- R5: Each non-DisplayPort head holds one PLL. When both PLLs are held, a non-DisplayPort request is rejected with reason 2.
- R6: A dual-link grant takes the lowest-numbered transmitter k whose two links are both free. It reports encoder 2k and `rsp_links`=11, and it holds both links and both encoders of that transmitter. If no transmitter has both links free, the request is rejected with reason 4, even when single links are free.
- R7: An analog grant takes the lowest-numbered free DAC and a PLL. It takes no encoder or link (`rsp_enc_used`=0).
- R8: Rejection causes are checked in a fixed order: timing controller (1), then PLL (2), then DAC (3), then link (4). A rejected request changes no ownership.
- R9: A release of an active head, taken while `busy` is low, pulses `rel_ack` one cycle later. It returns exactly the timing controller, PLL, DAC, links and encoders recorded for that head at grant time, so that later grants can reuse them.
- R10: A release of a head that is not active pulses `rel_bad` one cycle later and changes no ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_kind | input | 2 | Requested output kind |
| busy | output | 1 | A request is being checked or committed |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_grant | output | 1 | 1 = granted, 0 = rejected |
| rsp_reason | output | 3 | Rejection cause, 0 when granted |
| rsp_head | output | 3 | Granted timing controller |
| rsp_pll_used | output | 1 | A PLL was granted |
| rsp_pll | output | 1 | Granted PLL index |
| rsp_dac_used | output | 1 | A DAC was granted |
| rsp_dac | output | 1 | Granted DAC index |
| rsp_enc_used | output | 1 | An encoder and link were granted |
| rsp_enc | output | 3 | Granted encoder index |
| rsp_xmit | output | 2 | Granted transmitter index |
| rsp_links | output | 2 | Granted link mask (bit 0 = A, bit 1 = B) |
| rel_valid | input | 1 | Release strobe, taken while busy is low |
| rel_head | input | 3 | Head to release |
| rel_ack | output | 1 | Release freed an active head |
| rel_bad | output | 1 | Release named an inactive head |

## Verification
The hardest state to reach from the ports is a pool where links are free but split across transmitters, so that a dual-link request fails even though a single-link request would succeed. The stimulus builds this state with three DisplayPort grants that occupy transmitter 0 and one side of transmitter 1. It then places a dual-link grant, tries a second dual-link request, and follows it with a single-link request that must land on the lone free side. A later stage releases heads in between and refills every timing controller. This shows that released PLLs and links come back and that rejections follow the fixed order.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam logic [1:0] KIND_DP     = 2'd0;
  localparam logic [1:0] KIND_SINGLE = 2'd1;
  localparam logic [1:0] KIND_DUAL   = 2'd2;
  localparam logic [1:0] KIND_ANALOG = 2'd3;

  localparam logic [2:0] RSN_OK      = 3'd0;
  localparam logic [2:0] RSN_NO_HEAD = 3'd1;
  localparam logic [2:0] RSN_NO_PLL  = 3'd2;
  localparam logic [2:0] RSN_NO_DAC  = 3'd3;
  localparam logic [2:0] RSN_NO_LINK = 3'd4;
endpackage

// File: rtl/rp_first_free.sv
module rp_first_free #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  free_vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan downwards so the last hit is the smallest index
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rp_decide.sv
module rp_decide
  import rp_pkg::*;
#(
  parameter int NUM_HEADS = 6,
  parameter int NUM_PLL   = 2,
  parameter int NUM_DAC   = 2,
  parameter int NUM_XMIT  = 3,
  parameter int HW = 3,
  parameter int PW = 1,
  parameter int DW = 1,
  parameter int XW = 2,
  parameter int LW = 3
) (
  input  logic [1:0]            kind,
  input  logic [NUM_HEADS-1:0]  head_busy,
  input  logic [NUM_PLL-1:0]    pll_busy,
  input  logic [NUM_DAC-1:0]    dac_busy,
  input  logic [2*NUM_XMIT-1:0] link_busy,
  output logic                  grant,
  output logic [2:0]            reason,
  output logic [HW-1:0]         head_idx,
  output logic                  pll_used,
  output logic [PW-1:0]         pll_idx,
  output logic                  dac_used,
  output logic [DW-1:0]         dac_idx,
  output logic                  enc_used,
  output logic [LW-1:0]         enc_idx,
  output logic [XW-1:0]         xmit_idx,
  output logic [1:0]            links
);
  localparam int NL = 2 * NUM_XMIT;

  logic          head_ok, pll_ok, dac_ok, link_ok, pair_ok;
  logic [HW-1:0] head_sel;
  logic [PW-1:0] pll_sel;
  logic [DW-1:0] dac_sel;
  logic [LW-1:0] link_sel;
  logic [XW-1:0] pair_sel;
  logic [NUM_XMIT-1:0] pair_free;

  generate
    for (genvar k = 0; k < NUM_XMIT; k++) begin : g_pair
      assign pair_free[k] = ~link_busy[2*k] & ~link_busy[2*k+1];
    end
  endgenerate

  rp_first_free #(.W(NUM_HEADS), .IW(HW)) u_head (
    .free_vec(~head_busy), .found(head_ok), .idx(head_sel));
  rp_first_free #(.W(NUM_PLL), .IW(PW)) u_pll (
    .free_vec(~pll_busy), .found(pll_ok), .idx(pll_sel));
  rp_first_free #(.W(NUM_DAC), .IW(DW)) u_dac (
    .free_vec(~dac_busy), .found(dac_ok), .idx(dac_sel));
  rp_first_free #(.W(NL), .IW(LW)) u_link (
    .free_vec(~link_busy), .found(link_ok), .idx(link_sel));
  rp_first_free #(.W(NUM_XMIT), .IW(XW)) u_pairsel (
    .free_vec(pair_free), .found(pair_ok), .idx(pair_sel));

  logic need_pll, need_dac, need_link, need_pair;

  always_comb begin
    need_pll  = (kind != KIND_DP);
    need_dac  = (kind == KIND_ANALOG);
    need_link = (kind == KIND_DP) || (kind == KIND_SINGLE);
    need_pair = (kind == KIND_DUAL);

    if (!head_ok)                    reason = RSN_NO_HEAD;
    else if (need_pll && !pll_ok)    reason = RSN_NO_PLL;
    else if (need_dac && !dac_ok)    reason = RSN_NO_DAC;
    else if (need_link && !link_ok)  reason = RSN_NO_LINK;
    else if (need_pair && !pair_ok)  reason = RSN_NO_LINK;
    else                             reason = RSN_OK;
    grant = (reason == RSN_OK);

    head_idx = grant ? head_sel : '0;
    pll_used = grant && need_pll;
    pll_idx  = pll_used ? pll_sel : '0;
    dac_used = grant && need_dac;
    dac_idx  = dac_used ? dac_sel : '0;
    enc_used = grant && (need_link || need_pair);
    enc_idx  = '0;
    xmit_idx = '0;
    links    = 2'b00;
    if (grant && need_link) begin
      enc_idx  = link_sel;
      xmit_idx = link_sel[LW-1:1];
      links    = link_sel[0] ? 2'b10 : 2'b01;
    end else if (grant && need_pair) begin
      enc_idx  = {pair_sel, 1'b0};
      xmit_idx = pair_sel;
      links    = 2'b11;
    end
  end
endmodule

// File: rtl/rp_owner_table.sv
module rp_owner_table
  import rp_pkg::*;
#(
  parameter int NUM_HEADS = 6,
  parameter int NUM_PLL   = 2,
  parameter int NUM_DAC   = 2,
  parameter int NUM_XMIT  = 3,
  parameter int HW = 3,
  parameter int PW = 1,
  parameter int DW = 1,
  parameter int LW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_en,
  input  logic [1:0]            c_kind,
  input  logic [HW-1:0]         c_head,
  input  logic                  c_pll_used,
  input  logic [PW-1:0]         c_pll,
  input  logic                  c_dac_used,
  input  logic [DW-1:0]         c_dac,
  input  logic                  c_enc_used,
  input  logic [LW-1:0]         c_link,
  input  logic                  rel_en,
  input  logic [HW-1:0]         rel_head,
  output logic                  rel_hit,
  output logic [NUM_HEADS-1:0]  head_busy,
  output logic [NUM_PLL-1:0]    pll_busy,
  output logic [NUM_DAC-1:0]    dac_busy,
  output logic [2*NUM_XMIT-1:0] link_busy
);
  localparam int NL = 2 * NUM_XMIT;

  logic [NUM_HEADS-1:0] head_q, head_d;
  logic [NUM_PLL-1:0]   pll_q, pll_d;
  logic [NUM_DAC-1:0]   dac_q, dac_d;
  logic [NL-1:0]        link_q, link_d;
  logic [1:0]           rk_q [NUM_HEADS];
  logic [1:0]           rk_d [NUM_HEADS];
  logic [PW-1:0]        rp_q [NUM_HEADS];
  logic [PW-1:0]        rp_d [NUM_HEADS];
  logic [DW-1:0]        rd_q [NUM_HEADS];
  logic [DW-1:0]        rd_d [NUM_HEADS];
  logic [LW-1:0]        rl_q [NUM_HEADS];
  logic [LW-1:0]        rl_d [NUM_HEADS];
  logic                 tbl_en;

  assign tbl_en = commit_en || rel_hit;

  always_comb begin
    head_d = head_q;
    pll_d  = pll_q;
    dac_d  = dac_q;
    link_d = link_q;
    for (int h = 0; h < NUM_HEADS; h++) begin
      rk_d[h] = rk_q[h];
      rp_d[h] = rp_q[h];
      rd_d[h] = rd_q[h];
      rl_d[h] = rl_q[h];
    end
    rel_hit = rel_en && (32'(rel_head) < NUM_HEADS) && head_q[rel_head];
    if (rel_hit) begin
      head_d[rel_head] = 1'b0;
      if (rk_q[rel_head] != KIND_DP)     pll_d[rp_q[rel_head]] = 1'b0;
      if (rk_q[rel_head] == KIND_ANALOG) dac_d[rd_q[rel_head]] = 1'b0;
      if (rk_q[rel_head] == KIND_DP || rk_q[rel_head] == KIND_SINGLE)
        link_d[rl_q[rel_head]] = 1'b0;
      if (rk_q[rel_head] == KIND_DUAL) begin
        link_d[rl_q[rel_head]] = 1'b0;
        link_d[{rl_q[rel_head][LW-1:1], 1'b1}] = 1'b0;
      end
    end
    if (commit_en) begin
      head_d[c_head] = 1'b1;
      rk_d[c_head]   = c_kind;
      rp_d[c_head]   = c_pll;
      rd_d[c_head]   = c_dac;
      rl_d[c_head]   = c_link;
      if (c_pll_used) pll_d[c_pll] = 1'b1;
      if (c_dac_used) dac_d[c_dac] = 1'b1;
      if (c_enc_used) begin
        link_d[c_link] = 1'b1;
        if (c_kind == KIND_DUAL) link_d[{c_link[LW-1:1], 1'b1}] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      pll_q  <= '0;
      dac_q  <= '0;
      link_q <= '0;
      for (int h = 0; h < NUM_HEADS; h++) begin
        rk_q[h] <= '0;
        rp_q[h] <= '0;
        rd_q[h] <= '0;
        rl_q[h] <= '0;
      end
    end else if (tbl_en) begin
      head_q <= head_d;
      pll_q  <= pll_d;
      dac_q  <= dac_d;
      link_q <= link_d;
      for (int h = 0; h < NUM_HEADS; h++) begin
        rk_q[h] <= rk_d[h];
        rp_q[h] <= rp_d[h];
        rd_q[h] <= rd_d[h];
        rl_q[h] <= rl_d[h];
      end
    end
  end

  assign head_busy = head_q;
  assign pll_busy  = pll_q;
  assign dac_busy  = dac_q;
  assign link_busy = link_q;
endmodule

// File: rtl/display_alloc.sv
module display_alloc
  import rp_pkg::*;
#(
  parameter int NUM_HEADS = 6,
  parameter int NUM_PLL   = 2,
  parameter int NUM_DAC   = 2,
  parameter int NUM_XMIT  = 3,
  localparam int HW = (NUM_HEADS > 1) ? $clog2(NUM_HEADS) : 1,
  localparam int PW = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1,
  localparam int DW = (NUM_DAC > 1) ? $clog2(NUM_DAC) : 1,
  localparam int XW = (NUM_XMIT > 1) ? $clog2(NUM_XMIT) : 1,
  localparam int LW = XW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_grant,
  output logic [2:0]    rsp_reason,
  output logic [HW-1:0] rsp_head,
  output logic          rsp_pll_used,
  output logic [PW-1:0] rsp_pll,
  output logic          rsp_dac_used,
  output logic [DW-1:0] rsp_dac,
  output logic          rsp_enc_used,
  output logic [LW-1:0] rsp_enc,
  output logic [XW-1:0] rsp_xmit,
  output logic [1:0]    rsp_links,
  input  logic          rel_valid,
  input  logic [HW-1:0] rel_head,
  output logic          rel_ack,
  output logic          rel_bad
);
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_COMMIT} state_e;

  typedef struct packed {
    logic          grant;
    logic [2:0]    reason;
    logic [HW-1:0] head;
    logic          pll_used;
    logic [PW-1:0] pll;
    logic          dac_used;
    logic [DW-1:0] dac;
    logic          enc_used;
    logic [LW-1:0] enc;
    logic [XW-1:0] xmit;
    logic [1:0]    links;
  } dec_t;

  state_e state_q, state_d;
  logic [1:0] kind_q;
  logic       kind_en, dec_en, rsp_en;
  dec_t       dec_now, dec_q, rsp_q;
  logic       rsp_valid_q, rsp_valid_d;
  logic       commit_en, rel_en, rel_hit;
  logic       rel_ack_q, rel_ack_d, rel_bad_q, rel_bad_d;

  logic [NUM_HEADS-1:0]  head_busy;
  logic [NUM_PLL-1:0]    pll_busy;
  logic [NUM_DAC-1:0]    dac_busy;
  logic [2*NUM_XMIT-1:0] link_busy;

  rp_decide #(
    .NUM_HEADS(NUM_HEADS), .NUM_PLL(NUM_PLL), .NUM_DAC(NUM_DAC), .NUM_XMIT(NUM_XMIT),
    .HW(HW), .PW(PW), .DW(DW), .XW(XW), .LW(LW)
  ) u_decide (
    .kind(kind_q), .head_busy(head_busy), .pll_busy(pll_busy),
    .dac_busy(dac_busy), .link_busy(link_busy),
    .grant(dec_now.grant), .reason(dec_now.reason), .head_idx(dec_now.head),
    .pll_used(dec_now.pll_used), .pll_idx(dec_now.pll),
    .dac_used(dec_now.dac_used), .dac_idx(dec_now.dac),
    .enc_used(dec_now.enc_used), .enc_idx(dec_now.enc),
    .xmit_idx(dec_now.xmit), .links(dec_now.links)
  );

  rp_owner_table #(
    .NUM_HEADS(NUM_HEADS), .NUM_PLL(NUM_PLL), .NUM_DAC(NUM_DAC), .NUM_XMIT(NUM_XMIT),
    .HW(HW), .PW(PW), .DW(DW), .LW(LW)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .commit_en(commit_en), .c_kind(kind_q), .c_head(dec_q.head),
    .c_pll_used(dec_q.pll_used), .c_pll(dec_q.pll),
    .c_dac_used(dec_q.dac_used), .c_dac(dec_q.dac),
    .c_enc_used(dec_q.enc_used), .c_link(dec_q.enc),
    .rel_en(rel_en), .rel_head(rel_head), .rel_hit(rel_hit),
    .head_busy(head_busy), .pll_busy(pll_busy),
    .dac_busy(dac_busy), .link_busy(link_busy)
  );

  // releases are only taken between requests so the table never moves under a decision
  assign rel_en = rel_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    kind_en     = 1'b0;
    dec_en      = 1'b0;
    rsp_en      = 1'b0;
    commit_en   = 1'b0;
    rsp_valid_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          kind_en = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        dec_en  = 1'b1;
        state_d = ST_COMMIT;
      end
      ST_COMMIT: begin
        commit_en   = dec_q.grant;
        rsp_en      = 1'b1;
        rsp_valid_d = 1'b1;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    rel_ack_d = rel_hit;
    rel_bad_d = rel_en && !rel_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rel_ack_q   <= 1'b0;
      rel_bad_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rel_ack_q   <= rel_ack_d;
      rel_bad_q   <= rel_bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      dec_q  <= '0;
      rsp_q  <= '0;
    end else begin
      if (kind_en) kind_q <= req_kind;
      if (dec_en)  dec_q  <= dec_now;
      if (rsp_en)  rsp_q  <= dec_q;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign rsp_valid    = rsp_valid_q;
  assign rsp_grant    = rsp_q.grant;
  assign rsp_reason   = rsp_q.reason;
  assign rsp_head     = rsp_q.head;
  assign rsp_pll_used = rsp_q.pll_used;
  assign rsp_pll      = rsp_q.pll;
  assign rsp_dac_used = rsp_q.dac_used;
  assign rsp_dac      = rsp_q.dac;
  assign rsp_enc_used = rsp_q.enc_used;
  assign rsp_enc      = rsp_q.enc;
  assign rsp_xmit     = rsp_q.xmit;
  assign rsp_links    = rsp_q.links;
  assign rel_ack      = rel_ack_q;
  assign rel_bad      = rel_bad_q;
endmodule

// File: rtl/rp_checker.sv
module rp_checker
  import rp_pkg::*;
#(
  parameter int NUM_HEADS = 6,
  parameter int NUM_PLL   = 2,
  parameter int NL        = 6,
  parameter int LW        = 3,
  parameter int XW        = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 rsp_valid,
  input logic                 rsp_grant,
  input logic                 rsp_pll_used,
  input logic                 rsp_dac_used,
  input logic                 rsp_enc_used,
  input logic [LW-1:0]        rsp_enc,
  input logic [XW-1:0]        rsp_xmit,
  input logic [1:0]           rsp_links,
  input logic [1:0]           kind,
  input logic [NUM_HEADS-1:0] head_busy,
  input logic [NUM_PLL-1:0]   pll_busy,
  input logic [NL-1:0]        link_busy,
  input logic                 rel_ack,
  input logic                 rel_bad
);
  p_rsp_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));

  p_busy_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  p_dp_no_pll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && kind == KIND_DP) |-> (!rsp_pll_used && rsp_enc_used));

  p_enc_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && rsp_enc_used) |-> (rsp_xmit == rsp_enc[LW-1:1]));

  p_pll_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && rsp_pll_used) |-> !$past(&pll_busy));

  p_dual_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && kind == KIND_DUAL) |-> (rsp_links == 2'b11 && !rsp_enc[0]));

  p_analog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && kind == KIND_ANALOG) |-> (rsp_dac_used && rsp_pll_used && !rsp_enc_used));

  p_reject_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> ($stable(head_busy) && $stable(pll_busy) && $stable(link_busy)));

  p_rel_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_ack && rel_bad));

  p_rel_bad_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_bad |-> ($stable(head_busy) && $stable(link_busy)));
endmodule

bind display_alloc rp_checker #(
  .NUM_HEADS(NUM_HEADS), .NUM_PLL(NUM_PLL), .NL(2*NUM_XMIT), .LW(LW), .XW(XW)
) u_rp_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
  .rsp_pll_used(rsp_pll_used), .rsp_dac_used(rsp_dac_used), .rsp_enc_used(rsp_enc_used),
  .rsp_enc(rsp_enc), .rsp_xmit(rsp_xmit), .rsp_links(rsp_links), .kind(kind_q),
  .head_busy(head_busy), .pll_busy(pll_busy), .link_busy(link_busy),
  .rel_ack(rel_ack), .rel_bad(rel_bad)
);

// File: tb/test_display_alloc.sv
module test_display_alloc;
  import rp_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, req_valid, rel_valid;
  logic [1:0] req_kind;
  logic [2:0] rel_head;
  logic       busy, rsp_valid, rsp_grant, rsp_pll_used, rsp_dac_used, rsp_enc_used;
  logic [2:0] rsp_reason, rsp_head, rsp_enc;
  logic       rsp_pll, rsp_dac, rel_ack, rel_bad;
  logic [1:0] rsp_xmit, rsp_links;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  display_alloc i_display_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reason(rsp_reason),
    .rsp_head(rsp_head), .rsp_pll_used(rsp_pll_used), .rsp_pll(rsp_pll),
    .rsp_dac_used(rsp_dac_used), .rsp_dac(rsp_dac), .rsp_enc_used(rsp_enc_used),
    .rsp_enc(rsp_enc), .rsp_xmit(rsp_xmit), .rsp_links(rsp_links),
    .rel_valid(rel_valid), .rel_head(rel_head), .rel_ack(rel_ack), .rel_bad(rel_bad)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R1 handshake timing checked on every request
  task automatic issue(input logic [1:0] k);
    @(negedge clk); req_valid = 1'b1; req_kind = k;
    @(negedge clk); req_valid = 1'b0;
    chk("R1", "busy after accept", busy, 1);
    @(negedge clk);
    chk("R1", "busy second cycle", busy, 1);
    chk("R1", "no early response", rsp_valid, 0);
    @(negedge clk);
    chk("R1", "response strobe", rsp_valid, 1);
    chk("R1", "busy cleared", busy, 0);
  endtask

  task automatic exp_grant(input string req, input int head, input int pll_used, input int pll,
                           input int dac_used, input int dac, input int enc_used, input int enc,
                           input int xmit, input int links);
    chk(req, "grant", rsp_grant, 1);
    chk(req, "reason", rsp_reason, 0);
    chk("R2", "head", rsp_head, head);
    chk(req, "pll used", rsp_pll_used, pll_used);
    if (pll_used != 0) chk(req, "pll index", rsp_pll, pll);
    chk(req, "dac used", rsp_dac_used, dac_used);
    if (dac_used != 0) chk(req, "dac index", rsp_dac, dac);
    chk(req, "enc used", rsp_enc_used, enc_used);
    if (enc_used != 0) begin
      chk(req, "encoder", rsp_enc, enc);
      chk(req, "transmitter", rsp_xmit, xmit);
      chk(req, "links", rsp_links, links);
    end
  endtask

  task automatic exp_reject(input string req, input int reason);
    chk(req, "rejected", rsp_grant, 0);
    chk(req, "reason code", rsp_reason, reason);
  endtask

  task automatic release_head(input int h, input string req, input int ack, input int nack);
    @(negedge clk); rel_valid = 1'b1; rel_head = 3'(h);
    @(negedge clk); rel_valid = 1'b0;
    chk(req, "rel_ack", rel_ack, ack);
    chk(req, "rel_bad", rel_bad, nack);
  endtask

  task automatic t_reset;
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset rsp_valid", rsp_valid, 0);
    chk("R10", "reset rel_ack", rel_ack, 0);
  endtask

  task automatic t_dp_fill;
    issue(KIND_DP); exp_grant("R3", 0, 0, 0, 0, 0, 1, 0, 0, 1);
    @(negedge clk); chk("R1", "strobe one cycle", rsp_valid, 0);
    issue(KIND_DP); exp_grant("R3", 1, 0, 0, 0, 0, 1, 1, 0, 2);
    issue(KIND_DP); exp_grant("R3", 2, 0, 0, 0, 0, 1, 2, 1, 1);
  endtask

  task automatic t_dual_split;
    issue(KIND_DUAL);   exp_grant("R6", 3, 1, 0, 0, 0, 1, 4, 2, 3);
    issue(KIND_DUAL);   exp_reject("R6", 4);
    // R8: the rejected dual left link 3 and PLL 1 untouched
    issue(KIND_SINGLE); exp_grant("R4", 4, 1, 1, 0, 0, 1, 3, 1, 2);
  endtask

  task automatic t_pll_cap;
    issue(KIND_ANALOG); exp_reject("R5", 2);
  endtask

  task automatic t_release;
    release_head(1, "R9", 1, 0);
    release_head(1, "R10", 0, 1);
    release_head(5, "R10", 0, 1);
    issue(KIND_ANALOG); exp_reject("R5", 2);
    release_head(3, "R9", 1, 0);
    issue(KIND_ANALOG); exp_grant("R7", 1, 1, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_full;
    issue(KIND_DP);     exp_grant("R9", 3, 0, 0, 0, 0, 1, 1, 0, 2);
    issue(KIND_DP);     exp_grant("R9", 5, 0, 0, 0, 0, 1, 4, 2, 1);
    issue(KIND_DP);     exp_reject("R2", 1);
    issue(KIND_ANALOG); exp_reject("R8", 1);
    release_head(4, "R9", 1, 0);
    issue(KIND_SINGLE); exp_grant("R9", 4, 1, 1, 0, 0, 1, 3, 1, 2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; rel_valid = 1'b0; rel_head = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_dp_fill;
    t_dual_split;
    t_pll_cap;
    t_release;
    t_full;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule